// File: doc/BRIEF.md
# Zero-Crossing Mute Sequencer

This block decides when the left and right mute switches of a stereo audio path open and close. Control comes from two register bits: a general-mute request and a crossing-mode select. A strobe marks each write of the word that holds the mute bit. Each channel also has its own zero-crossing strobe, and an active-low hardware mute pin sits above everything else. With crossing mode off, the mute request reaches both switches directly. With crossing mode on, a change is held pending and each channel switches at its own next zero crossing. A timeout counter restarts on every write and forces the change if no crossing arrives in time.

Each channel runs a two-state machine. In `CH_IDLE` the switch agrees with the request. In `CH_PEND` a change is waiting.

The transitions are named as follows:
- `CH_IDLE -> CH_PEND` (request differs, crossing mode on).
- `CH_PEND -> CH_IDLE` by crossing or timeout, which applies the request.
- `CH_PEND -> CH_IDLE` by cancel, when the request returns to the current switch state. Nothing switches.
- Any state `-> CH_IDLE` when crossing mode is off, with the request copied directly.

The pin gates the outputs combinationally and stores nothing.

Top module: `zc_mute_seq`

## Requirements
- R1: With `zc_mode` = 0 at a rising clock edge, both bus switch states take the value of `gen_mute` at that edge. The outputs show it right after the edge (1 = muted).
- R2: With `zc_mode` = 1, a channel's switch state holds through any edge where that channel's crossing strobe is low and the timeout has not expired.
- R3: With a change pending, a channel switches at the first later edge where its own crossing strobe is high. The other channel is unaffected.
- R4: A pending change is applied at the edge where `TIMEOUT_CYCLES` edges have passed since the last `word_wr` pulse, even without a crossing.
- R5: Each `word_wr` pulse restarts the timeout count from zero, even if `gen_mute` is unchanged.
- R6: While `hw_mute_n` is low, `mute_left` and `mute_right` are both 1 in the same cycle, whatever the bus state.
- R7: The pin stores nothing. When it returns high, the outputs immediately show the bus switch states, including any switching that happened while the pin was low.
- R8: Reset (`rst_n` low) sets both switch states to muted and clears any pending change.
- R9: A pending change whose request returns to the current switch state is dropped without switching. Later crossings have no effect.
- R10: A later write replaces a pending request, because the pending target is always the current `gen_mute`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| gen_mute | input | 1 | General mute request bit (1 = mute) |
| zc_mode | input | 1 | 1 = switch at zero crossings, 0 = switch directly |
| word_wr | input | 1 | One-cycle pulse when the mute register word is written |
| zc_left | input | 1 | Left channel zero-crossing strobe |
| zc_right | input | 1 | Right channel zero-crossing strobe |
| hw_mute_n | input | 1 | Hardware mute pin, active low |
| mute_left | output | 1 | Left mute switch (1 = muted) |
| mute_right | output | 1 | Right mute switch (1 = muted) |

## Verification
Some rules are checked by the assertions on every clock:
- the direct copy when crossing mode is off;
- each channel holding its state when neither its crossing nor the timeout is present;
- the timeout applying a pending change;
- a cancelled request returning a channel to idle without switching;
- a write clearing the expired flag.

Other behaviour only the bench scenarios show:
- the combinational pin override, and the pin storing nothing;
- the muted state after reset;
- one channel switching while the other still waits;
- the exact edge at which a restarted timeout fires.

The bench compares both outputs to a behavioural model on every clock.

// File: rtl/zcm_pkg.sv
package zcm_pkg;
    typedef enum logic {
        CH_IDLE = 1'b0,
        CH_PEND = 1'b1
    } ch_state_t;
endpackage

// File: rtl/zcm_timer.sv
module zcm_timer #(
    parameter int TIMEOUT_CYCLES = 4800000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    output logic expired
);
    localparam int CW = $clog2(TIMEOUT_CYCLES + 1);
    localparam logic [CW-1:0] LIMIT = CW'(TIMEOUT_CYCLES);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (restart) begin
            cnt_q <= '0;
        end else if (cnt_q != LIMIT) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign expired = (cnt_q == LIMIT);

    // R5: a write always starts a fresh window
    a_r5_restart: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> !expired);
endmodule

// File: rtl/zcm_channel.sv
module zcm_channel
    import zcm_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic gen_mute,
    input  logic zc_mode,
    input  logic zc_hit,
    input  logic expired,
    output logic sw_mute
);
    ch_state_t state_q, state_d;
    logic      sw_q, sw_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= CH_IDLE;
            sw_q    <= 1'b1;
        end else begin
            state_q <= state_d;
            sw_q    <= sw_d;
        end
    end

    // next state and switch value
    always_comb begin
        state_d = state_q;
        sw_d    = sw_q;
        if (!zc_mode) begin
            state_d = CH_IDLE;
            sw_d    = gen_mute;
        end else begin
            unique case (state_q)
                CH_IDLE: begin
                    if (gen_mute != sw_q) state_d = CH_PEND;
                end
                CH_PEND: begin
                    if (gen_mute == sw_q) begin
                        state_d = CH_IDLE;
                    end else if (zc_hit || expired) begin
                        sw_d    = gen_mute;
                        state_d = CH_IDLE;
                    end
                end
            endcase
        end
    end

    assign sw_mute = sw_q;

    a_r1_direct: assert property (@(posedge clk) disable iff (!rst_n)
        !zc_mode |=> sw_q == $past(gen_mute));

    // R2 and R3: no own crossing and no timeout means no switching
    a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (zc_mode && !zc_hit && !expired) |=> $stable(sw_q));

    a_r4_timeout: assert property (@(posedge clk) disable iff (!rst_n)
        (zc_mode && state_q == CH_PEND && expired && gen_mute != sw_q)
            |=> (sw_q == $past(gen_mute)) && state_q == CH_IDLE);

    a_r9_cancel: assert property (@(posedge clk) disable iff (!rst_n)
        (zc_mode && state_q == CH_PEND && gen_mute == sw_q)
            |=> state_q == CH_IDLE && $stable(sw_q));
endmodule

// File: rtl/zc_mute_seq.sv
module zc_mute_seq #(
    parameter int TIMEOUT_CYCLES = 4800000,
    parameter int NUM_CH         = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic gen_mute,
    input  logic zc_mode,
    input  logic word_wr,
    input  logic zc_left,
    input  logic zc_right,
    input  logic hw_mute_n,
    output logic mute_left,
    output logic mute_right
);
    logic              expired;
    logic [NUM_CH-1:0] zc_vec;
    logic [NUM_CH-1:0] sw_vec;

    assign zc_vec = NUM_CH'({zc_right, zc_left});

    zcm_timer #(.TIMEOUT_CYCLES(TIMEOUT_CYCLES)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (word_wr),
        .expired (expired)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        zcm_channel u_ch (
            .clk      (clk),
            .rst_n    (rst_n),
            .gen_mute (gen_mute),
            .zc_mode  (zc_mode),
            .zc_hit   (zc_vec[c]),
            .expired  (expired),
            .sw_mute  (sw_vec[c])
        );
    end

    // pin override: combinational, nothing stored
    assign mute_left  = sw_vec[0] | ~hw_mute_n;
    assign mute_right = sw_vec[NUM_CH-1] | ~hw_mute_n;
endmodule

// File: tb/test_zc_mute_seq.sv
module test_zc_mute_seq;
    localparam int CLK_PERIOD = 10;
    localparam int T          = 20;

    logic clk = 0, rst_n = 0, gen_mute = 1, zc_mode = 0, word_wr = 0;
    logic zc_left = 0, zc_right = 0, hw_mute_n = 1;
    logic mute_left, mute_right;

    always #(CLK_PERIOD/2) clk = ~clk;

    zc_mute_seq #(.TIMEOUT_CYCLES(T)) i_zc_mute_seq (
        .clk(clk), .rst_n(rst_n), .gen_mute(gen_mute), .zc_mode(zc_mode),
        .word_wr(word_wr), .zc_left(zc_left), .zc_right(zc_right),
        .hw_mute_n(hw_mute_n), .mute_left(mute_left), .mute_right(mute_right)
    );

    int    total = 0, bad = 0;
    string phase = "R8 reset";
    int    m_cnt = 0;
    bit    m_sw [2];
    bit    m_pend [2];

    task automatic check(input logic act, input logic exp, input string which);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: got %0b expected %0b", phase, which, act, exp);
        end
    endtask

    // reference model, compared on every clock
    always @(posedge clk) begin
        bit exp_now;
        bit z [2];
        if (!rst_n) begin
            m_cnt = 0;
            for (int c = 0; c < 2; c++) begin m_sw[c] = 1; m_pend[c] = 0; end
        end else begin
            exp_now = (m_cnt == T);
            if (word_wr) m_cnt = 0;
            else if (m_cnt < T) m_cnt++;
            z[0] = zc_left; z[1] = zc_right;
            for (int c = 0; c < 2; c++) begin
                if (!zc_mode) begin
                    m_sw[c] = gen_mute; m_pend[c] = 0;
                end else if (!m_pend[c]) begin
                    if (gen_mute != m_sw[c]) m_pend[c] = 1;
                end else if (gen_mute == m_sw[c]) begin
                    m_pend[c] = 0;
                end else if (z[c] || exp_now) begin
                    m_sw[c] = gen_mute; m_pend[c] = 0;
                end
            end
        end
        #1;
        check(mute_left,  m_sw[0] | !hw_mute_n, "left");
        check(mute_right, m_sw[1] | !hw_mute_n, "right");
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic write_word(input logic g, input logic z);
        @(negedge clk); gen_mute = g; zc_mode = z; word_wr = 1;
        @(negedge clk); word_wr = 0;
    endtask

    task automatic pulse_zc(input logic l, input logic r);
        @(negedge clk); zc_left = l; zc_right = r;
        @(negedge clk); zc_left = 0; zc_right = 0;
    endtask

    task automatic finish_run();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        bad++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        idle(3);
        rst_n = 1;
        idle(5);                                  // R8: outputs stay muted
        phase = "R1 direct";
        write_word(0, 0); idle(3);
        write_word(1, 0); idle(3);
        phase = "R2 R3 crossing";
        write_word(0, 1); idle(5);
        pulse_zc(1, 0); idle(3);                  // only left unmutes
        pulse_zc(0, 1); idle(3);
        phase = "R9 R10 cancel";
        write_word(1, 1); idle(2);
        write_word(0, 1); idle(2);                // replaced, matches state
        pulse_zc(1, 1); idle(25);                 // must stay unmuted
        phase = "R4 timeout";
        write_word(1, 1); idle(25);
        phase = "R5 restart";
        write_word(0, 1); idle(12);
        write_word(0, 1); idle(12);
        idle(12);
        phase = "R6 R7 pin";
        @(negedge clk); hw_mute_n = 0; idle(3);
        @(negedge clk); hw_mute_n = 1; idle(3);
        @(negedge clk); hw_mute_n = 0;
        write_word(1, 1); idle(2);
        pulse_zc(1, 0); idle(2);
        @(negedge clk); hw_mute_n = 1; idle(5);   // left muted, right pending
        idle(T);
        finish_run();
    end
endmodule